// File: doc/BRIEF.md
# Dual-Clock FIFO with Threshold Flags

This block moves 36-bit words from a write clock domain into an unrelated read clock domain. The write side sees a full flag and an almost-full flag. The read side sees an empty flag, an almost-empty flag and a valid strobe. Each pointer crosses into the other domain in Gray code through a two-flop synchronizer. Each domain works out its own flags from its own pointer and the late copy of the other pointer. Because that copy lags, a flag can clear later than the true state allows, but it never clears early.

The read port runs in first-word-fall-through style. A one-word output stage prefetches from the storage array, so the oldest word already sits on the read data port, with valid high, before any read strobe is given. A read strobe while valid is high consumes that word, and the stage refills from storage when a word is waiting there. A single active-low reset covers both domains. It is asserted asynchronously and released separately in each domain after two clock edges. The reset should be held for at least three cycles of each clock.

Top module: `dcfifo_thresh`

## Requirements
- R1: While reset is held and once it is released, empty and almost-empty are high, full and almost-full are low and valid is low; words stored before a reset never appear afterwards.
- R2: Every accepted word leaves the read port exactly once, all 36 bits intact and in write order, whatever the relative rate and pattern of writes and reads.
- R3: Fall-through: when a word is stored, it appears on the read data port with valid high without a read strobe. A read strobe while valid is high presents the next stored word in the following read cycle.
- R4: Empty is always the inverse of valid. When the last held word is read, valid falls in the next read clock cycle.
- R5: A write while full is high is dropped, and the pointers do not move.
- R6: A read strobe while valid is low has no effect, and later words still come out in order.
- R7: The storage array holds 512 words and the output stage holds one more. With reads idle, exactly 513 writes are accepted before full stays high.
- R8: Almost-full is high when the free storage (512 minus the words still in the array, not counting the output stage) is 256 or less. With reads idle and the flags settled, it is low after 256 accepted writes and high after 257. Full implies almost-full.
- R9: Almost-empty is high when the words held (array plus output stage) number 128 or fewer. With reads idle and settled, it is high at 128 words and low at 129. Empty implies almost-empty.
- R10: Each pointer that crosses a domain changes by at most one bit per clock of its own domain.
- R11: While valid is high and no read strobe is given, valid and the read data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_full | output | 1 | Storage array full; writes are dropped |
| wr_afull | output | 1 | Free storage at or below the almost-full level |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read strobe; consumes the presented word |
| rd_data | output | 36 | Head word (fall-through) |
| rd_valid | output | 1 | rd_data holds an unread word |
| rd_empty | output | 1 | No word presented |
| rd_aempty | output | 1 | Held words at or below the almost-empty level |

## Verification
The bench drives the capacity edge: it fills the FIFO with reads idle until full, then keeps writing marked words. A design that let one of those marked words through, or that shifted the write pointer, makes the scoreboard see an unexpected word or a gap. It steps the fill count across each threshold, at 128 and 129 words and at 256 and 257 writes. An off-by-one compare or a count that leaves out the output stage flips the flag at the wrong step. It holds the read strobe high while the FIFO is empty, pulses single reads to check fall-through and the one-cycle drop of valid, and resets the FIFO with words still inside, where a design with a stale output stage would give a word back after reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  function automatic logic [31:0] bin_to_gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) begin
      b[i] = ^(g >> i);
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int AF_LVL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_s,
  output logic              full,
  output logic              afull,
  output logic              wr_ok,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_s, used;
  int            free_w;

  always_comb begin
    rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
    used    = wbin_q - rbin_s;
    free_w  = DEPTH - int'(used);
    full    = (int'(used) == DEPTH);
    afull   = (free_w <= AF_LVL);
    wr_ok   = wr_en & ~full;
    wbin_d  = wbin_q + PW'(wr_ok);
    wgray_d = PW'(bin_to_gray(32'(wbin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_ok) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wbin_q[ADDR_W-1:0];
  assign wgray = wgray_q;

  // R5
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wbin_q));
  // R8
  full_afull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> afull);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) <= DEPTH);
  // R10
  wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9,
  parameter int AE_LVL = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] rd_data,
  output logic              valid,
  output logic              empty,
  output logic              aempty
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0]     rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0]     wbin_s, ram_cnt;
  logic              fetch, valid_q, valid_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  int                held;

  always_comb begin
    wbin_s  = PW'(gray_to_bin(32'(wgray_s)));
    ram_cnt = wbin_s - rbin_q;
    fetch   = (ram_cnt != '0) & (~valid_q | rd_en);
    rbin_d  = rbin_q + PW'(fetch);
    rgray_d = PW'(bin_to_gray(32'(rbin_d)));
    if (fetch)      valid_d = 1'b1;
    else if (rd_en) valid_d = 1'b0;
    else            valid_d = valid_q;
    dout_d  = fetch ? mem_q : dout_q;
    held    = int'(ram_cnt) + int'(valid_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (fetch) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
        dout_q  <= dout_d;
      end
    end
  end

  assign raddr   = rbin_q[ADDR_W-1:0];
  assign rgray   = rgray_q;
  assign rd_data = dout_q;
  assign valid   = valid_q;
  assign empty   = ~valid_q;
  assign aempty  = (held <= AE_LVL);

  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rd_en) |=> (valid_q && $stable(dout_q)));
  // R4
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rd_en && ram_cnt == '0) |=> !valid_q);
  // R9
  empty_aempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> aempty);
  // R7
  rd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ram_cnt) <= DEPTH);
  // R10
  rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcfifo_thresh.sv
module dcfifo_thresh #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9,
  parameter int AE_LVL = 128,
  parameter int AF_LVL = 256
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_afull,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_empty,
  output logic              rd_aempty
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wrst_n, rrst_n, wr_ok;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;

  dcf_rst_sync i_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync i_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_sync2 #(.W(PW)) i_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  dcf_sync2 #(.W(PW)) i_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_wr_side #(.ADDR_W(ADDR_W), .AF_LVL(AF_LVL)) i_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .full(wr_full), .afull(wr_afull), .wr_ok(wr_ok), .waddr(waddr), .wgray(wgray)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_ok) mem[waddr] <= wr_data;
  end

  assign mem_q = mem[raddr];

  dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_LVL(AE_LVL)) i_rd (
    .clk(rd_clk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s), .mem_q(mem_q),
    .raddr(raddr), .rgray(rgray), .rd_data(rd_data), .valid(rd_valid),
    .empty(rd_empty), .aempty(rd_aempty)
  );
endmodule

// File: tb/test_dcfifo_thresh.sv
module test_dcfifo_thresh;
  localparam int DW    = 36;
  localparam int DEPTH = 512;

  logic          rst_n = 1'b0;
  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full, wr_afull, rd_valid, rd_empty, rd_aempty;
  logic [DW-1:0] rd_data;

  int            n_chk = 0, n_err = 0;
  logic [DW-1:0] sb[$];
  int            rd_mode = 0;   // 0 idle, 1 always, 2 pseudo-random, 3 single pulse
  logic [15:0]   lfsr = 16'hACE1;
  bit            done = 1'b0;

  always #10 wr_clk = ~wr_clk;  // 50 MHz write clock
  always #13.5 rd_clk = ~rd_clk;

  dcfifo_thresh i_dcfifo_thresh (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_afull(wr_afull), .rd_clk(rd_clk), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_aempty(rd_aempty)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: drives rd_en at read negedges and pops the scoreboard
  initial begin
    forever begin
      @(negedge rd_clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rd_mode)
        1: rd_en = 1'b1;
        2: rd_en = lfsr[0] | lfsr[3];
        3: begin rd_en = 1'b1; rd_mode = 0; end
        default: rd_en = 1'b0;
      endcase
      chk(rd_empty == ~rd_valid, "R4 empty/valid", DW'(rd_empty), DW'(~rd_valid));
      if (rd_en && rd_valid) begin
        if (sb.size() == 0) chk(1'b0, "R2 unexpected word", rd_data, '0);
        else begin
          logic [DW-1:0] e;
          e = sb.pop_front();
          chk(rd_data == e, "R2 order/data", rd_data, e);
        end
      end
    end
  end

  task automatic wr_one(input logic [DW-1:0] d);
    while (wr_full) @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d; sb.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_force(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    if (!wr_full) sb.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge wr_clk);
  endtask

  task automatic do_reset();
    rd_mode = 0;
    @(negedge wr_clk);
    rst_n = 1'b0;
    repeat (5) @(negedge rd_clk);
    chk(rd_empty && rd_aempty && !rd_valid, "R1 read flags in reset", {rd_empty, rd_aempty, rd_valid}, 3'b110);
    chk(!wr_full && !wr_afull, "R1 write flags in reset", {wr_full, wr_afull}, 2'b00);
    sb.delete();
    rst_n = 1'b1;
    repeat (6) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic drain();
    rd_mode = 2;
    while (sb.size() != 0) @(negedge rd_clk);
    repeat (4) @(negedge rd_clk);
    rd_mode = 0;
    repeat (2) @(negedge rd_clk);
    chk(!rd_valid && rd_empty && rd_aempty, "R2 drained flags", {rd_valid, rd_empty, rd_aempty}, 3'b011);
  endtask

  initial begin
    int acc;
    do_reset();
    chk(rd_empty && rd_aempty && !rd_valid, "R1 after release", {rd_empty, rd_aempty, rd_valid}, 3'b110);
    chk(!wr_full && !wr_afull, "R1 write after release", {wr_full, wr_afull}, 2'b00);

    // R3 fall-through and advance, R4 valid drop
    wr_one(36'hA_1111_0001);
    wr_one(36'hB_2222_0002);
    repeat (12) @(negedge rd_clk);
    chk(rd_valid && rd_data == 36'hA_1111_0001, "R3 head word shown", rd_data, 36'hA_1111_0001);
    repeat (3) @(negedge rd_clk);
    chk(rd_data == 36'hA_1111_0001, "R11 head held", rd_data, 36'hA_1111_0001);
    rd_mode = 3;
    wait (rd_mode == 0);
    @(negedge rd_clk);
    chk(rd_valid && rd_data == 36'hB_2222_0002, "R3 next word", rd_data, 36'hB_2222_0002);
    rd_mode = 3;
    wait (rd_mode == 0);
    @(negedge rd_clk);
    chk(!rd_valid, "R4 valid falls after last", DW'(rd_valid), '0);

    // R6 read strobe while empty
    rd_mode = 1;
    repeat (10) @(negedge rd_clk);
    chk(!rd_valid, "R6 no word from empty", DW'(rd_valid), '0);
    @(negedge wr_clk);
    for (int i = 0; i < 20; i++) wr_one(DW'(36'h6_0000_0000 + i));
    drain();

    // thresholds and capacity with reads idle
    @(negedge wr_clk);
    acc = 0;
    for (int i = 0; i < 128; i++) begin wr_one(DW'(36'h7_0000_0000 + acc)); acc++; end
    settle(); @(negedge rd_clk);
    chk(rd_aempty, "R9 aempty at 128", DW'(rd_aempty), 1);
    @(negedge wr_clk);
    wr_one(DW'(36'h7_0000_0000 + acc)); acc++;
    settle(); @(negedge rd_clk);
    chk(!rd_aempty, "R9 aempty at 129", DW'(rd_aempty), 0);
    @(negedge wr_clk);
    while (acc < 256) begin wr_one(DW'(36'h7_0000_0000 + acc)); acc++; end
    settle();
    chk(!wr_afull, "R8 afull at 256", DW'(wr_afull), 0);
    wr_one(DW'(36'h7_0000_0000 + acc)); acc++;
    settle();
    chk(wr_afull && !wr_full, "R8 afull at 257", {wr_afull, wr_full}, 2'b10);
    while (!wr_full) begin wr_one(DW'(36'h7_0000_0000 + acc)); acc++; end
    settle();
    chk(wr_full, "R7 full held", DW'(wr_full), 1);
    chk(acc == DEPTH + 1, "R7 capacity", DW'(acc), DW'(DEPTH + 1));
    // R5 writes while full are dropped
    for (int i = 0; i < 10; i++) wr_force(36'hF_DEAD_0000 | DW'(i));
    chk(sb.size() == DEPTH + 1, "R5 nothing extra accepted", DW'(sb.size()), DW'(DEPTH + 1));
    drain();

    // mixed rates
    @(negedge wr_clk);
    rd_mode = 2;
    for (int i = 0; i < 600; i++) begin
      wr_one(DW'({4'h9, 32'(i * 32'h9E37_79B9)}));
      repeat (i % 3) @(negedge wr_clk);
    end
    drain();

    // R1 reset with words inside
    @(negedge wr_clk);
    for (int i = 0; i < 40; i++) wr_one(DW'(36'h3_0000_0000 + i));
    settle();
    do_reset();
    rd_mode = 1;
    repeat (12) @(negedge rd_clk);
    chk(!rd_valid && rd_aempty, "R1 no stale word", {rd_valid, rd_aempty}, 2'b01);
    rd_mode = 0;

    chk(sb.size() == 0, "R2 scoreboard empty", DW'(sb.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog timeout actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule